// File: doc/BRIEF.md
# Isochronous Cycle Timer and Monitor

This block keeps the serial-bus cycle time for a link controller. It holds a nested timestamp made of a seconds field, a cycle field and an offset field. The offset steps once per external tick, so the timestamp can be driven from any timebase while the logic runs on the core clock. Each time the offset rolls over, a new 125 us isochronous cycle begins. The host reads the timestamp at any time. A host write is held until the next tick and is then applied in place of the increment.

When the node is cycle master, the block raises a one-clock cycle-start request at every cycle boundary, so that the arbiter can send a cycle-start packet. As a slave, it copies the timestamp carried by each received cycle-start into its register. It also watches for a missing cycle-start and reports it as cycle lost. In both roles it reports a cycle-start event. At every cycle boundary it samples a request bit that enables the arbitration enhancements for the cycle that follows.

Top module: `cycle_timer_monitor`

## Requirements
- R1: While reset is asserted and on the first clock after it, rd_data, cs_req, cs_event, cycle_lost and accel_en are all zero.
- R2: rd_data holds seconds in bits [31:25], cycle in bits [24:12] and offset in bits [11:0]. On a tick, the offset advances by one. After offset 3071 the offset returns to 0 and the cycle advances. After cycle 7999 the cycle returns to 0 and the seconds advance, wrapping modulo 128. The change is visible on the clock after the tick.
- R3: On a clock with no tick and no slave cycle-start load, rd_data does not change.
- R4: A host write with no tick in the same clock is held pending, and a later write replaces it. On the first clock with a tick, the value loads in place of the increment. A write in the same clock as a tick loads at once.
- R5: With master_en high, cs_req is a one-clock pulse in the clock where rd_data first shows offset 0 because of a rollover by increment. cs_req is never high with master_en low, and a load that sets the offset to 0 does not raise it.
- R6: cs_event pulses together with cs_req in master mode. In slave mode it pulses on the clock after rx_cs_valid.
- R7: In slave mode, rx_cs_valid loads rx_cs_time into rd_data on the next clock. This load takes priority over a host write, and that write stays pending. In master mode, rx_cs_valid has no effect.
- R8: In slave mode, once a cycle-start has been received, cycle_lost pulses for one clock if 3072+16 ticks pass with no further cycle-start. A cycle-start that arrives on the clock of the final tick prevents the pulse. No pulse occurs before the first cycle-start, or in master mode.
- R9: accel_en takes the value of accel_next at each cycle boundary, in the same clock in which cs_event rises. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advances the offset by one |
| master_en | input | 1 | 1: cycle master, 0: slave |
| wr_en | input | 1 | Host write strobe for the timestamp |
| wr_data | input | 32 | Host write value |
| rd_data | output | 32 | Current timestamp {seconds, cycle, offset} |
| rx_cs_valid | input | 1 | A cycle-start packet was received |
| rx_cs_time | input | 32 | Timestamp carried by the received cycle-start |
| accel_next | input | 1 | Enhancement enable requested for the next cycle |
| cs_req | output | 1 | Cycle-start send request (master) |
| cs_event | output | 1 | Cycle-start event pulse |
| cycle_lost | output | 1 | Missing cycle-start pulse (slave) |
| accel_en | output | 1 | Arbitration enhancement enable for the current cycle |

## Verification
The hardest case to reach is the cycle-lost window edge, where a cycle-start arrives on exactly the clock of the final tick in the window. To get there, the bench sends one cycle-start and then counts ticks, timing the next pulse to land on that clock. A reduced offset range keeps the window short, so the case is also driven one tick later, where the loss must fire. The same reduced ranges let the seconds rollover, and a pending host write landing just before a cycle boundary, be reached in a few hundred clocks.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

   // Source of a timestamp load on a given clock.
   typedef enum logic [1:0] {
      LD_NONE = 2'd0,
      LD_RX   = 2'd1,
      LD_HOST = 2'd2
   } ld_src_e;

   // Counter width needed to hold the values 0..n.
   function automatic int unsigned ctm_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ctm_stamp.sv
module ctm_stamp
   import ctm_pkg::*;
#(
   parameter int unsigned SEC_W   = 7,
   parameter int unsigned CYC_W   = 13,
   parameter int unsigned OFS_W   = 12,
   parameter int unsigned CYC_MAX = 8000,
   parameter int unsigned OFS_MAX = 3072,
   localparam int unsigned TW     = SEC_W + CYC_W + OFS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          rx_load,
   input  logic [TW-1:0] rx_time,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_data,
   output logic [TW-1:0] time_o,
   output logic          roll_o
);

   if (OFS_MAX < 2 || OFS_MAX > (1 << OFS_W)) begin : g_bad_ofs
      $error("ctm_stamp: OFS_MAX does not fit OFS_W");
   end
   if (CYC_MAX < 2 || CYC_MAX > (1 << CYC_W)) begin : g_bad_cyc
      $error("ctm_stamp: CYC_MAX does not fit CYC_W");
   end
   if (SEC_W < 1) begin : g_bad_sec
      $error("ctm_stamp: SEC_W must be at least 1");
   end

   logic [TW-1:0]    stamp_q;
   logic [TW-1:0]    stamp_d;
   logic             pend_q;
   logic [TW-1:0]    pend_data_q;
   ld_src_e          src;

   logic [OFS_W-1:0] ofs;
   logic [CYC_W-1:0] cyc;
   logic [SEC_W-1:0] sec;
   logic             ofs_last;
   logic             cyc_last;
   logic [TW-1:0]    bumped;

   assign ofs = stamp_q[OFS_W-1:0];
   assign cyc = stamp_q[OFS_W +: CYC_W];
   assign sec = stamp_q[TW-1 -: SEC_W];

   // Last offset value: a full-width all-ones test when the range is a power of two.
   if (OFS_MAX == (1 << OFS_W)) begin : g_ofs_pow2
      assign ofs_last = &ofs;
   end else begin : g_ofs_cmp
      assign ofs_last = (ofs == OFS_W'(OFS_MAX - 1));
   end

   if (CYC_MAX == (1 << CYC_W)) begin : g_cyc_pow2
      assign cyc_last = &cyc;
   end else begin : g_cyc_cmp
      assign cyc_last = (cyc == CYC_W'(CYC_MAX - 1));
   end

   always_comb begin
      logic [OFS_W-1:0] n_ofs;
      logic [CYC_W-1:0] n_cyc;
      logic [SEC_W-1:0] n_sec;
      n_ofs = ofs_last ? '0 : ofs + OFS_W'(1);
      n_cyc = cyc;
      n_sec = sec;
      if (ofs_last) begin
         n_cyc = cyc_last ? '0 : cyc + CYC_W'(1);
         if (cyc_last) n_sec = sec + SEC_W'(1);
      end
      bumped = {n_sec, n_cyc, n_ofs};
   end

   always_comb begin
      if (rx_load)                       src = LD_RX;
      else if (tick_en && (wr_en || pend_q)) src = LD_HOST;
      else                               src = LD_NONE;
   end

   always_comb begin
      unique case (src)
         LD_RX:   stamp_d = rx_time;
         LD_HOST: stamp_d = wr_en ? wr_data : pend_data_q;
         default: stamp_d = tick_en ? bumped : stamp_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp_q     <= '0;
         pend_q      <= 1'b0;
         pend_data_q <= '0;
      end else begin
         stamp_q <= stamp_d;
         if (src == LD_HOST) begin
            pend_q <= 1'b0;
         end else if (wr_en) begin
            pend_q      <= 1'b1;
            pend_data_q <= wr_data;
         end
      end
   end

   assign time_o = stamp_q;
   assign roll_o = (src == LD_NONE) && tick_en && ofs_last;

   // R3
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !rx_load) |=> $stable(time_o));

   // R4
   write_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && wr_en && !rx_load) |=> (time_o == $past(wr_data)));

   // R7
   rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> (time_o == $past(rx_time)));

endmodule

// File: rtl/ctm_lost_watch.sv
module ctm_lost_watch
   import ctm_pkg::*;
#(
   parameter int unsigned OFS_MAX = 3072,
   parameter int unsigned MARGIN  = 16,
   parameter bit          LOST_EN = 1'b1,
   localparam int unsigned LIMIT  = OFS_MAX + MARGIN,
   localparam int unsigned CW     = ctm_bits(LIMIT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic slave_i,
   input  logic rx_seen_i,
   output logic lost_o
);

   if (LIMIT < 2) begin : g_bad_limit
      $error("ctm_lost_watch: window too short");
   end

   if (LOST_EN) begin : g_watch
      logic          armed_q;
      logic [CW-1:0] cnt_q;
      logic          lost_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            lost_q  <= 1'b0;
         end else begin
            lost_q <= 1'b0;
            if (!slave_i) begin
               armed_q <= 1'b0;
               cnt_q   <= '0;
            end else if (rx_seen_i) begin
               armed_q <= 1'b1;
               cnt_q   <= '0;
            end else if (armed_q && tick_en) begin
               if (cnt_q == CW'(LIMIT - 1)) begin
                  lost_q  <= 1'b1;
                  armed_q <= 1'b0;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
         end
      end

      assign lost_o = lost_q;
   end else begin : g_no_watch
      assign lost_o = 1'b0;
   end

   // R8
   no_lost_after_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_seen_i |=> !lost_o);

   // R8
   lost_only_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lost_o |-> $past(slave_i));

endmodule

// File: rtl/ctm_accel_gate.sv
module ctm_accel_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic bound_i,
   input  logic next_i,
   output logic en_o
);

   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (bound_i) en_q <= next_i;
   end

   assign en_o = en_q;

   // R9
   accel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bound_i |=> $stable(en_o));

endmodule

// File: rtl/cycle_timer_monitor.sv
module cycle_timer_monitor #(
   parameter int unsigned SEC_W       = 7,
   parameter int unsigned CYC_W       = 13,
   parameter int unsigned OFS_W       = 12,
   parameter int unsigned CYC_MAX     = 8000,
   parameter int unsigned OFS_MAX     = 3072,
   parameter int unsigned LOST_MARGIN = 16,
   parameter bit          LOST_EN     = 1'b1,
   localparam int unsigned TW         = SEC_W + CYC_W + OFS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          master_en,
   input  logic          wr_en,
   input  logic [TW-1:0] wr_data,
   output logic [TW-1:0] rd_data,
   input  logic          rx_cs_valid,
   input  logic [TW-1:0] rx_cs_time,
   input  logic          accel_next,
   output logic          cs_req,
   output logic          cs_event,
   output logic          cycle_lost,
   output logic          accel_en
);

   logic rx_load;
   logic roll;
   logic boundary;
   logic cs_req_q;
   logic cs_evt_q;

   assign rx_load  = rx_cs_valid && !master_en;
   assign boundary = master_en ? roll : rx_load;

   ctm_stamp #(
      .SEC_W   (SEC_W),
      .CYC_W   (CYC_W),
      .OFS_W   (OFS_W),
      .CYC_MAX (CYC_MAX),
      .OFS_MAX (OFS_MAX)
   ) u_stamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .rx_load (rx_load),
      .rx_time (rx_cs_time),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .time_o  (rd_data),
      .roll_o  (roll)
   );

   ctm_lost_watch #(
      .OFS_MAX (OFS_MAX),
      .MARGIN  (LOST_MARGIN),
      .LOST_EN (LOST_EN)
   ) u_lost (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .slave_i   (!master_en),
      .rx_seen_i (rx_load),
      .lost_o    (cycle_lost)
   );

   ctm_accel_gate u_accel (
      .clk     (clk),
      .rst_n   (rst_n),
      .bound_i (boundary),
      .next_i  (accel_next),
      .en_o    (accel_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_req_q <= 1'b0;
         cs_evt_q <= 1'b0;
      end else begin
         cs_req_q <= master_en && roll;
         cs_evt_q <= boundary;
      end
   end

   assign cs_req   = cs_req_q;
   assign cs_event = cs_evt_q;

   // R5
   req_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_req |-> ((rd_data[OFS_W-1:0] == '0) && cs_event));

   // R5
   req_master_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_req |-> $past(master_en));

   // R6
   slave_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cs_valid && !master_en) |=> cs_event);

endmodule

// File: tb/cycle_timer_monitor_tb.sv
module cycle_timer_monitor_tb;

   localparam int SEC_W = 7;
   localparam int CYC_W = 13;
   localparam int OFS_W = 12;
   localparam int CYC_MAX = 5;
   localparam int OFS_MAX = 40;
   localparam int MARGIN = 4;
   localparam int LIMIT = OFS_MAX + MARGIN;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        master_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        rx_cs_valid = 1'b0;
   logic [31:0] rx_cs_time = '0;
   logic        accel_next = 1'b0;
   logic        cs_req, cs_event, cycle_lost, accel_en;

   int n_checks = 0;
   int n_errors = 0;
   int n_clk = 0;

   always #4 clk = ~clk;

   cycle_timer_monitor #(
      .SEC_W(SEC_W), .CYC_W(CYC_W), .OFS_W(OFS_W),
      .CYC_MAX(CYC_MAX), .OFS_MAX(OFS_MAX), .LOST_MARGIN(MARGIN)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .master_en(master_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .rx_cs_valid(rx_cs_valid), .rx_cs_time(rx_cs_time),
      .accel_next(accel_next), .cs_req(cs_req), .cs_event(cs_event),
      .cycle_lost(cycle_lost), .accel_en(accel_en)
   );

   typedef struct {
      logic [31:0] t;
      logic        req;
      logic        ev;
      logic        lost;
      logic        acc;
      string       ttag;
   } exp_t;

   exp_t sb_q[$];

   function automatic logic [31:0] mk(input int s, input int c, input int o);
      return {7'(s), 13'(c), 12'(o)};
   endfunction

   // Reference state, advanced once per rising edge from the requirements.
   logic [31:0] m_time = '0;
   logic        m_pend = 1'b0;
   logic [31:0] m_pdata = '0;
   logic        m_armed = 1'b0;
   int          m_cnt = 0;
   logic        m_acc = 1'b0;

   // Expectation producer: pushes what the outputs must show after this edge.
   always @(posedge clk) begin
      exp_t e;
      int   s, c, o;
      logic roll, bound;
      n_clk++;
      e.req = 1'b0; e.ev = 1'b0; e.lost = 1'b0;
      if (!rst_n) begin
         m_time = '0; m_pend = 1'b0; m_armed = 1'b0; m_cnt = 0; m_acc = 1'b0;
         e.ttag = "R1";
      end else begin
         s = int'(m_time[31:25]); c = int'(m_time[24:12]); o = int'(m_time[11:0]);
         roll = 1'b0;
         if (rx_cs_valid && !master_en) begin
            m_time = rx_cs_time; e.ttag = "R7";
            if (wr_en) begin m_pend = 1'b1; m_pdata = wr_data; end
         end else if (tick_en && (wr_en || m_pend)) begin
            m_time = wr_en ? wr_data : m_pdata; m_pend = 1'b0; e.ttag = "R4";
         end else if (tick_en) begin
            o++;
            if (o == OFS_MAX) begin
               o = 0; roll = 1'b1; c++;
               if (c == CYC_MAX) begin c = 0; s = (s + 1) % 128; end
            end
            m_time = mk(s, c, o); e.ttag = "R2";
            if (wr_en) begin m_pend = 1'b1; m_pdata = wr_data; end
         end else begin
            e.ttag = "R3";
            if (wr_en) begin m_pend = 1'b1; m_pdata = wr_data; end
         end
         bound = master_en ? roll : rx_cs_valid;
         e.req = master_en && roll;
         e.ev  = bound;
         if (bound) m_acc = accel_next;
         // R8 window model
         if (master_en) begin
            m_armed = 1'b0; m_cnt = 0;
         end else if (rx_cs_valid) begin
            m_armed = 1'b1; m_cnt = 0;
         end else if (m_armed && tick_en) begin
            m_cnt++;
            if (m_cnt == LIMIT) begin e.lost = 1'b1; m_armed = 1'b0; m_cnt = 0; end
         end
      end
      e.t = m_time;
      e.acc = m_acc;
      sb_q.push_back(e);
   end

   task automatic check(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s actual=%h expected=%h at clock %0d", tag, what, act, exp, n_clk);
      end
   endtask

   // Monitor: compares outputs half a period after each edge.
   always @(negedge clk) begin
      exp_t e;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         check(e.ttag, "rd_data", rd_data, e.t);
         check(rst_n ? "R5" : "R1", "cs_req", 32'(cs_req), 32'(e.req));
         check(rst_n ? "R6" : "R1", "cs_event", 32'(cs_event), 32'(e.ev));
         check(rst_n ? "R8" : "R1", "cycle_lost", 32'(cycle_lost), 32'(e.lost));
         check(rst_n ? "R9" : "R1", "accel_en", 32'(accel_en), 32'(e.acc));
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic [31:0] v);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_rx(input logic [31:0] v);
      rx_cs_valid = 1'b1; rx_cs_time = v;
      @(negedge clk);
      rx_cs_valid = 1'b0;
   endtask

   initial begin
      // R1: reset state
      run(4);
      rst_n = 1'b1;
      // R2 R5 R6 R9: master counting through cycle and seconds rollover
      master_en = 1'b1; tick_en = 1'b1; accel_next = 1'b1;
      run(100);
      accel_next = 1'b0;
      run(150);
      accel_next = 1'b1;
      run(250);
      // R3: sparse ticks
      for (int i = 0; i < 120; i++) begin
         tick_en = (i % 3 == 0);
         run(1);
      end
      // R4: write held without tick, latest wins, then loads near a rollover (seconds wrap)
      tick_en = 1'b0;
      host_write(mk(5, 1, 2));
      run(2);
      host_write(mk(127, 4, 36));
      run(5);
      tick_en = 1'b1;
      run(10);
      // R4: write in the same clock as a tick
      host_write(mk(3, 2, 10));
      run(3);
      // R5: write setting offset 0 must not raise cs_req
      host_write(mk(2, 2, 0));
      run(3);
      // R7: received cycle-start ignored in master mode
      pulse_rx(mk(9, 3, 7));
      run(5);
      // R6 R7 R8: slave mode with regular cycle-starts
      master_en = 1'b0;
      run(60);
      for (int k = 0; k < 4; k++) begin
         pulse_rx(mk(1, k, 0));
         run(OFS_MAX - 1);
      end
      // R8: starts stop, loss fires after the window
      run(LIMIT + 10);
      // R8: start arriving on the final tick of the window prevents the loss
      pulse_rx(mk(4, 1, 0));
      run(LIMIT - 1);
      pulse_rx(mk(4, 2, 0));
      run(LIMIT + 2);
      // R7: rx and host write in one clock, rx wins, write applies on next tick
      tick_en = 1'b0;
      wr_en = 1'b1; wr_data = mk(6, 3, 20);
      pulse_rx(mk(7, 4, 5));
      wr_en = 1'b0;
      run(4);
      tick_en = 1'b1;
      run(4);
      // R8: no ticks, no loss; then switch to master while armed
      tick_en = 1'b0;
      pulse_rx(mk(0, 0, 0));
      run(80);
      tick_en = 1'b1;
      master_en = 1'b1;
      run(LIMIT + 20);
      run(3);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #800000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule